// File: doc/BRIEF.md
# Flat-Sum Radix-16 Signed Dot Product

This block forms the dot product of four signed 16-bit multiplier operands with four signed 17-bit multiplicand operands in one pass. The 17-bit multiplicand width leaves room for a butterfly sum or difference of two 16-bit samples. Each multiplier operand is cut into four 4-bit digits. Every digit is multiplied against its lane's multiplicand, giving sixteen small products in all. Each product is built as a grid of partial-product bits in positive-only form. Any bit that pairs one operand's sign with a non-sign bit of the other is inverted. Each grid is folded into a sum word and a carry word without carry propagation.

All thirty-two sum and carry words go into one flat compressor tree made of 4:2 compressors. A single folded constant word goes in with them and cancels the bias that the inverted bits introduce. No product is ever completed on its own and there is no accumulator. One carry-lookahead adder resolves the two surviving words into the result. An optional output register sets the latency to zero or one clock.

Top module: `dotp_radix_core`

## Requirements
- R1: `dot_out` equals the exact sum over lanes i of U_i×V_i in 35-bit two's complement. Lane i of U is `u_vec[i]` (16-bit signed) and lane i of V is `v_vec[i]` (17-bit signed).
- R2: U = -32768 and V = -65536 in every lane gives +2^33, with no wrap into the sign bit.
- R3: U = -32768 and V = +65535 in every lane gives -4·32768·65535.
- R4: U all zero gives zero whatever V holds.
- R5: Every bit set in every lane (-1 × -1) gives +4.
- R6: A lane whose U or V is zero adds nothing, and the other lanes' products are unaffected.
- R7: Bits [4r+3:4r] of U carry weight 2^(4r) for r = 0..2. In the top digit, bit 15 carries weight -2^15.
- R8: With the output register enabled, the result for the inputs seen at one rising edge appears after that edge and holds while the inputs stay unchanged.
- R9: `rst_n` low clears `dot_out` to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| u_vec | input | 4×16 | Signed multiplier operand per lane |
| v_vec | input | 4×17 | Signed multiplicand operand per lane |
| dot_out | output | 35 | Signed dot product |

## Verification
The extreme operand pairs are the ones most likely to expose errors. Most-negative by most-negative shows whether the sign-by-sign bit and the folded constant are right. Most-negative by most-positive tests the inverted cross terms. All-ones tests the case where every inverted bit drops to zero. The digit walk places one nonzero digit at a time and separates the weighting of the three unsigned digits from the signed top digit. Zeroed lanes mixed with live lanes and four hundred random vectors then check exactness in general, and an unchanged input held over several clocks shows the register latency.

// File: rtl/dotp_pkg.sv
`timescale 1ns/1ps
package dotp_pkg;

  // words left after one reduction level: four become two, a leftover three becomes two
  function automatic int next_cnt(input int c);
    int rem;
    rem = c % 4;
    return 2 * (c / 4) + ((rem == 3) ? 2 : rem);
  endfunction

  function automatic int cnt_at(input int n0, input int lvl);
    int c;
    c = n0;
    for (int i = 0; i < lvl; i++) c = next_cnt(c);
    return c;
  endfunction

  function automatic int n_levels(input int n0);
    int c;
    int l;
    c = n0;
    l = 0;
    for (int i = 0; i < 64; i++) begin
      if (c > 2) begin
        c = next_cnt(c);
        l++;
      end
    end
    return l;
  endfunction

  // word offset of a level inside the flat pool
  function automatic int off_at(input int n0, input int lvl);
    int o;
    o = 0;
    for (int i = 0; i < lvl; i++) o += cnt_at(n0, i);
    return o;
  endfunction

endpackage

// File: rtl/dotp_comp42.sv
`timescale 1ns/1ps
// Word-wide 4:2 compressor: two chained carry-save stages; the first stage's
// XOR result enters the second stage, its majority output becomes the lateral carry.
module dotp_comp42 #(
  parameter int W = 35
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cy_o
);
  logic [W-1:0] x1;
  logic [W-1:0] m1;
  logic [W-1:0] lat;
  logic [W-1:0] m2;

  assign x1    = a ^ b ^ c;
  assign m1    = (a & b) | (a & c) | (b & c);
  assign lat   = m1 << 1;
  assign sum_o = x1 ^ d ^ lat;
  assign m2    = (x1 & d) | (x1 & lat) | (d & lat);
  assign cy_o  = m2 << 1;
endmodule

// File: rtl/dotp_digit_pp.sv
`timescale 1ns/1ps
// One digit x operand product in positive-only form, left as sum and carry words.
module dotp_digit_pp #(
  parameter int DIG   = 4,
  parameter int VW    = 17,
  parameter int RW    = 35,
  parameter int SHIFT = 0,
  parameter bit TOP   = 1'b0
) (
  input  logic [DIG-1:0] dig,
  input  logic [VW-1:0]  vop,
  output logic [RW-1:0]  sum_w,
  output logic [RW-1:0]  carry_w
);
  logic [RW-1:0] row [DIG];

  // bit grid: invert where exactly one factor is a sign bit
  always_comb begin : grid
    logic pp_b;
    logic inv_b;
    for (int a = 0; a < DIG; a++) begin
      row[a] = '0;
      for (int j = 0; j < VW; j++) begin
        pp_b  = dig[a] & vop[j];
        inv_b = (j == VW - 1) ^ (TOP && (a == DIG - 1));
        row[a][SHIFT + a + j] = inv_b ? ~pp_b : pp_b;
      end
    end
  end

  // fold the rows with a chain of carry-save adders, no propagation
  always_comb begin : fold
    logic [RW-1:0] s_acc;
    logic [RW-1:0] c_acc;
    logic [RW-1:0] x_t;
    logic [RW-1:0] m_t;
    s_acc = row[0];
    c_acc = row[1];
    for (int a = 2; a < DIG; a++) begin
      x_t   = s_acc ^ c_acc ^ row[a];
      m_t   = (s_acc & c_acc) | (s_acc & row[a]) | (c_acc & row[a]);
      s_acc = x_t;
      c_acc = m_t << 1;
    end
    sum_w   = s_acc;
    carry_w = c_acc;
  end
endmodule

// File: rtl/dotp_ctree.sv
`timescale 1ns/1ps
// Flat reduction of NIN words to two, built level by level from 4:2 compressors.
module dotp_ctree #(
  parameter int W   = 35,
  parameter int NIN = 33
) (
  input  logic [W-1:0] din [NIN],
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  localparam int LEV   = dotp_pkg::n_levels(NIN);
  localparam int TOTAL = dotp_pkg::off_at(NIN, LEV + 1);
  localparam int LAST  = dotp_pkg::off_at(NIN, LEV);

  logic [W-1:0] pool [TOTAL];

  for (genvar i = 0; i < NIN; i++) begin : g_load
    assign pool[i] = din[i];
  end

  for (genvar l = 1; l <= LEV; l++) begin : g_lvl
    localparam int CP = dotp_pkg::cnt_at(NIN, l - 1);
    localparam int IB = dotp_pkg::off_at(NIN, l - 1);
    localparam int OB = dotp_pkg::off_at(NIN, l);
    localparam int G  = CP / 4;
    localparam int R  = CP % 4;

    for (genvar g = 0; g < G; g++) begin : g_c42
      dotp_comp42 #(.W(W)) u_c42 (
        .a(pool[IB + 4*g]), .b(pool[IB + 4*g + 1]),
        .c(pool[IB + 4*g + 2]), .d(pool[IB + 4*g + 3]),
        .sum_o(pool[OB + 2*g]), .cy_o(pool[OB + 2*g + 1])
      );
    end

    if (R == 3) begin : g_c32
      dotp_comp42 #(.W(W)) u_c32 (
        .a(pool[IB + 4*G]), .b(pool[IB + 4*G + 1]),
        .c(pool[IB + 4*G + 2]), .d('0),
        .sum_o(pool[OB + 2*G]), .cy_o(pool[OB + 2*G + 1])
      );
    end else begin : g_pass
      for (genvar i = 0; i < R; i++) begin : g_w
        assign pool[OB + 2*G + i] = pool[IB + 4*G + i];
      end
    end
  end

  assign s_o = pool[LAST];
  assign c_o = pool[LAST + 1];
endmodule

// File: rtl/dotp_cla.sv
`timescale 1ns/1ps
// Carry-lookahead adder: expanded lookahead inside each group, group carries chained.
module dotp_cla #(
  parameter int W   = 35,
  parameter int GRP = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum_o
);
  localparam int NG = (W + GRP - 1) / GRP;

  logic [W-1:0]  gen;
  logic [W-1:0]  prp;
  logic [W-1:0]  cin_b;
  logic [NG-1:0] cin_g;

  assign gen = a & b;
  assign prp = a ^ b;

  always_comb begin : look
    logic cj;
    logic pr;
    int   base;
    cin_b = '0;
    cin_g = '0;
    for (int k = 0; k < NG; k++) begin
      base = k * GRP;
      // every bit carry of the group straight from the group carry-in
      for (int j = 0; j < GRP; j++) begin
        if (base + j < W) begin
          cj = 1'b0;
          pr = 1'b1;
          for (int m = j - 1; m >= 0; m--) begin
            cj = cj | (pr & gen[base + m]);
            pr = pr & prp[base + m];
          end
          cin_b[base + j] = cj | (pr & cin_g[k]);
        end
      end
      // group carry-out
      if (k + 1 < NG) begin
        cj = 1'b0;
        pr = 1'b1;
        for (int m = GRP - 1; m >= 0; m--) begin
          cj = cj | (pr & gen[base + m]);
          pr = pr & prp[base + m];
        end
        cin_g[k + 1] = cj | (pr & cin_g[k]);
      end
    end
  end

  assign sum_o = prp ^ cin_b;
endmodule

// File: rtl/dotp_radix_core.sv
`timescale 1ns/1ps
module dotp_radix_core #(
  parameter int NE      = 4,
  parameter int UW      = 16,
  parameter int VW      = 17,
  parameter int DIG     = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NE-1:0][UW-1:0]        u_vec,
  input  logic [NE-1:0][VW-1:0]        v_vec,
  output logic [UW+VW+$clog2(NE)-1:0]  dot_out
);
  localparam int K      = UW / DIG;
  localparam int RW     = UW + VW + $clog2(NE);
  localparam int NPP    = NE * K;
  localparam int NWORDS = 2 * NPP + 1;

  localparam logic [RW-1:0] ONE      = {{(RW-1){1'b0}}, 1'b1};
  // bias of the inverted bits for one lane, then for all lanes
  localparam logic [RW-1:0] BIAS_ONE = (ONE << (VW-1)) + (ONE << (UW-1)) - (ONE << (UW+VW-1));
  localparam logic [RW-1:0] CORR     = BIAS_ONE * RW'(NE);

  logic [RW-1:0] words [NWORDS];
  logic [RW-1:0] red_s;
  logic [RW-1:0] red_c;
  logic [RW-1:0] dot_sum;

  for (genvar e = 0; e < NE; e++) begin : g_lane
    for (genvar r = 0; r < K; r++) begin : g_dig
      dotp_digit_pp #(
        .DIG(DIG), .VW(VW), .RW(RW), .SHIFT(r*DIG), .TOP(r == K-1)
      ) u_pp (
        .dig    (u_vec[e][r*DIG +: DIG]),
        .vop    (v_vec[e]),
        .sum_w  (words[2*(e*K + r)]),
        .carry_w(words[2*(e*K + r) + 1])
      );
    end
  end

  assign words[NWORDS-1] = CORR;

  dotp_ctree #(.W(RW), .NIN(NWORDS)) u_tree (
    .din(words), .s_o(red_s), .c_o(red_c)
  );

  dotp_cla #(.W(RW), .GRP(4)) u_cla (
    .a(red_s), .b(red_c), .sum_o(dot_sum)
  );

  if (REG_OUT) begin : g_reg
    logic [RW-1:0] dot_d;
    logic [RW-1:0] dot_q;

    always_comb begin
      dot_d = dot_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dot_q <= '0;
      else        dot_q <= dot_d;
    end

    assign dot_out = dot_q;
  end else begin : g_comb
    logic unused_ok;
    assign unused_ok = clk ^ rst_n;
    assign dot_out   = dot_sum;
  end
endmodule

// File: rtl/dotp_radix_core_chk.sv
`timescale 1ns/1ps
module dotp_radix_core_chk #(
  parameter int NE      = 4,
  parameter int UW      = 16,
  parameter int VW      = 17,
  parameter bit REG_OUT = 1'b1,
  parameter int RW      = UW + VW + $clog2(NE)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NE-1:0][UW-1:0] u_vec,
  input logic [NE-1:0][VW-1:0] v_vec,
  input logic [RW-1:0]         dot_out
);
  localparam logic [RW-1:0] ONE = {{(RW-1){1'b0}}, 1'b1};
  localparam logic [NE-1:0][UW-1:0] UMIN = {NE{{1'b1, {(UW-1){1'b0}}}}};
  localparam logic [NE-1:0][VW-1:0] VMIN = {NE{{1'b1, {(VW-1){1'b0}}}}};
  localparam logic [NE-1:0][VW-1:0] VMAX = {NE{{1'b0, {(VW-1){1'b1}}}}};
  localparam logic [RW-1:0] EXP_MM  = RW'(NE) << (UW + VW - 2);
  localparam logic [RW-1:0] MAG_MX  = (((ONE << (VW-1)) - ONE) * RW'(NE)) << (UW-1);
  localparam logic [RW-1:0] EXP_MX  = ~MAG_MX + ONE;

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R9: reset holds the output at zero
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r9_reset_zero: assert (dot_out == '0) else $error("reset output not zero");
    end
  end

  if (REG_OUT) begin : g_seq
    a_r2_minmin: assert property (@(posedge clk) disable iff (!rst_n)
      (u_vec == UMIN && v_vec == VMIN) |=> (dot_out == EXP_MM))
      else $error("min x min wrong");

    a_r3_minmax: assert property (@(posedge clk) disable iff (!rst_n)
      (u_vec == UMIN && v_vec == VMAX) |=> (dot_out == EXP_MX))
      else $error("min x max wrong");

    a_r4_zero_u: assert property (@(posedge clk) disable iff (!rst_n)
      (u_vec == '0) |=> (dot_out == '0))
      else $error("zero U gave nonzero");

    a_r5_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (&u_vec && &v_vec) |=> (dot_out == RW'(NE)))
      else $error("all ones wrong");

    a_r6_zero_v: assert property (@(posedge clk) disable iff (!rst_n)
      (v_vec == '0) |=> (dot_out == '0))
      else $error("zero V gave nonzero");

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $stable(u_vec) && $stable(v_vec)) |=> $stable(dot_out))
      else $error("output moved with steady inputs");
  end
endmodule

bind dotp_radix_core dotp_radix_core_chk #(
  .NE(NE), .UW(UW), .VW(VW), .REG_OUT(REG_OUT)
) i_chk (
  .clk(clk), .rst_n(rst_n), .u_vec(u_vec), .v_vec(v_vec), .dot_out(dot_out)
);

// File: tb/test_dotp_radix_core.sv
`timescale 1ns/1ps
module test_dotp_radix_core;
  localparam int NE = 4;
  localparam int UW = 16;
  localparam int VW = 17;
  localparam int RW = 35;

  typedef logic [NE-1:0][UW-1:0] uvec_t;
  typedef logic [NE-1:0][VW-1:0] vvec_t;
  typedef struct {
    logic [RW-1:0] exp;
    int            due;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  uvec_t         u_vec;
  vvec_t         v_vec;
  logic [RW-1:0] dot_out;

  exp_t q[$];
  exp_t head;
  int   cyc   = 0;
  int   total = 0;
  int   bad   = 0;

  always #2.5 clk = ~clk;

  dotp_radix_core i_dotp_radix_core (
    .clk(clk), .rst_n(rst_n), .u_vec(u_vec), .v_vec(v_vec), .dot_out(dot_out)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [RW-1:0] ref_dot(input uvec_t u, input vvec_t v);
    longint acc;
    acc = 0;
    for (int e = 0; e < NE; e++)
      acc += longint'($signed(u[e])) * longint'($signed(v[e]));
    return acc[RW-1:0];
  endfunction

  task automatic check(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference comparison on every clock: the head entry falls due one edge after driving
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      head = q.pop_front();
      check(head.tag, dot_out, head.exp);
    end
  end

  task automatic drive(input uvec_t u, input vvec_t v, input string tag);
    u_vec = u;
    v_vec = v;
    q.push_back('{exp: ref_dot(u, v), due: cyc + 1, tag: tag});
    @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    u_vec = '1;
    v_vec = '1;
    #1 check("R9", dot_out, '0);
    repeat (3) @(negedge clk);
    check("R9", dot_out, '0);
    rst_n = 1'b1;

    drive('0, {17'h1FFFF, 17'h0FFFF, 17'h10000, 17'h00123}, "R4");
    drive('1, '1, "R5");
    drive({NE{16'h8000}}, {NE{17'h10000}}, "R2");
    drive({NE{16'h8000}}, {NE{17'h0FFFF}}, "R3");
    drive({NE{16'h7FFF}}, {NE{17'h10000}}, "R3");

    // digit walk: one nonzero digit at a time in lane 0
    for (int r = 0; r < 4; r++) begin
      uvec_t u1;
      u1 = '0;
      u1[0] = 16'h000F << (4*r);
      drive(u1, {17'h0, 17'h0, 17'h0, 17'h00001}, "R7");
      drive(u1, {17'h0, 17'h0, 17'h0, 17'h1FFFD}, "R7");
    end
    drive({16'hF000, 16'h0F00, 16'h00F0, 16'h000F}, {NE{17'h00003}}, "R7");
    drive({16'h8001, 16'h7FFF, 16'h0800, 16'hFFF0}, {17'h0F0F0, 17'h1FFFF, 17'h0ABCD, 17'h10001}, "R7");

    // zero lanes mixed with live ones
    drive({16'h0000, 16'h7FFF, 16'hFFB3, 16'd1234}, {17'h10000, 17'd500, 17'h1FFFF, 17'h00000}, "R6");
    drive({16'h8000, 16'h0000, 16'h1234, 16'h0000}, {17'h0FFFF, 17'h10000, 17'h00000, 17'h1FFFF}, "R6");

    // steady inputs across clocks, then alternating inputs
    repeat (3) drive({16'h4321, 16'h8765, 16'h0FED, 16'hCBA9}, {17'h13579, 17'h02468, 17'h1ACE0, 17'h0BDF1}, "R8");
    drive({NE{16'h8000}}, {NE{17'h10000}}, "R8");
    drive('1, '1, "R8");
    drive({NE{16'h8000}}, {NE{17'h10000}}, "R8");

    for (int n = 0; n < 400; n++) begin
      uvec_t ru;
      vvec_t rv;
      for (int e = 0; e < NE; e++) begin
        ru[e] = UW'($urandom);
        rv[e] = VW'($urandom);
        if (n % 8 == 0) begin
          ru[e] = ($urandom_range(0, 1) == 1) ? 16'h8000 : 16'h7FFF;
          rv[e] = ($urandom_range(0, 1) == 1) ? 17'h10000 : 17'h0FFFF;
        end
      end
      drive(ru, rv, "R1");
    end

    drive({16'h1111, 16'h2222, 16'h3333, 16'h4444}, {17'h00055, 17'h1FF00, 17'h00777, 17'h0ABCD}, "R1");
    drain();

    // reset in the middle of operation
    rst_n = 1'b0;
    #1 check("R9", dot_out, '0);
    @(negedge clk);
    check("R9", dot_out, '0);
    rst_n = 1'b1;
    drive({NE{16'h8000}}, {NE{17'h10000}}, "R2");
    drive('1, '1, "R5");
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule